// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block derives a steady one-microsecond event stream from whatever reference clock it runs on. A configuration word holds two small integers, a multiply term and a divide term, chosen so that mul/div equals one microsecond per reference period. An accumulator adds the multiply term on every reference cycle. Each time the sum reaches the divide term, the block subtracts that term and raises a one-cycle tick. The ticks are therefore spread evenly. For a ratio that is not a whole number, such as a 19.2 MHz reference, the long-term rate is still exactly one tick per microsecond.

Each tick advances a free-running up-counter that other timers and software read as a microsecond timestamp. The configuration word can be written and read back, so its value can be saved and restored. A freeze input halts the whole timebase, which lets a debugger or a low-power sequence hold time still.

Top module: `usec_timebase`

## Requirements
- R1: After reset the configuration reads back 0x000B (mul 1, div 12, the 12 MHz setting), the counter reads 0 and tick is low.
- R2: In the configuration word, bits [15:8] hold mul-1 and bits [7:0] hold div-1. A written word reads back unchanged on cfg_rdata from the cycle after the write. This also holds for a write made while freeze is high.
- R3: After a configuration write, with freeze low, the counter has advanced by exactly floor(k*mul/div) after k reference cycles. Over any div such cycles it therefore advances by exactly mul.
- R4: The ratios 1/12, 1/13, 5/84, 5/96, 1/26, 5/192 and 1/48 each produce exactly N*mul ticks over N*div unfrozen cycles.
- R5: tick is high for exactly one cycle per count step. The counter rises by one in each cycle where tick is high and holds its value in every other cycle.
- R6: The counter counts upward and wraps from its all-ones value to zero with no other effect.
- R7: A configuration write clears the accumulator and keeps the counter value. No tick occurs in the cycle after the write.
- R8: While freeze is high, the accumulator and the counter hold their values and no tick is issued. Counting resumes from the held state once freeze is released.
- R9: If the encoded mul is larger than div, mul is treated as equal to div, and a tick is issued on every unfrozen cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word to write: mul-1 in [15:8], div-1 in [7:0] |
| cfg_rdata | output | 16 | Current configuration word |
| freeze | input | 1 | Holds the accumulator and counter while high |
| tick | output | 1 | One-cycle strobe, one per microsecond |
| us_count | output | CNT_W (32) | Free-running microsecond counter |

## Verification
The counter is compared on every cycle against floor(k*mul/div), where k counts only unfrozen cycles. This is run for each of the seven listed ratios and for random configuration words, so that a wrong tick position or a drifting ratio is caught at the first cycle where it appears. Random freeze patterns are overlaid on these runs, which separates a correct hold from a design that loses or repeats accumulator state across a freeze. Directed cases cover the rest. A rewrite in the middle of a window shows whether the accumulator is cleared. An oversized mul shows whether it is clamped. A second, narrow-counter instance runs long enough to wrap.

// File: rtl/usec_pkg.sv
package usec_pkg;
  // width of one ratio field (mul-1 or div-1)
  parameter int TERM_W = 8;
  localparam int FIELD_W = 2 * TERM_W;

  // a term holds values 1 .. 2**TERM_W
  typedef logic [TERM_W:0] term_t;

  typedef struct packed {
    term_t mul;
    term_t div;
  } ratio_t;

  // reset word: mul 1, div 12
  localparam logic [FIELD_W-1:0] BOOT_FIELD = {TERM_W'(0), TERM_W'(11)};

  function automatic term_t field_to_term(logic [TERM_W-1:0] f);
    return term_t'(f) + term_t'(1);
  endfunction

  // decode the stored word into usable terms; mul is clamped to div
  function automatic ratio_t decode_ratio(logic [FIELD_W-1:0] w);
    ratio_t r;
    r.mul = field_to_term(w[FIELD_W-1:TERM_W]);
    r.div = field_to_term(w[TERM_W-1:0]);
    if (r.mul > r.div) r.mul = r.div;
    return r;
  endfunction
endpackage

// File: rtl/usec_cfg_reg.sv
module usec_cfg_reg
  import usec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] rd_data,
  output ratio_t             ratio
);
  logic [FIELD_W-1:0] field_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     field_q <= BOOT_FIELD;
    else if (wr_en) field_q <= wr_data;
  end

  assign rd_data = field_q;
  assign ratio   = decode_ratio(field_q);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));
endmodule

// File: rtl/usec_rate_gen.sv
module usec_rate_gen
  import usec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   hold,
  input  ratio_t ratio,
  output logic   step
);
  localparam int ACC_W = TERM_W + 2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic             reach;

  function automatic logic [ACC_W-1:0] add_mul(logic [ACC_W-1:0] a, term_t m);
    return a + ACC_W'(m);
  endfunction

  function automatic logic [ACC_W-1:0] fold(logic [ACC_W-1:0] s, term_t d, logic hit);
    return hit ? s - ACC_W'(d) : s;
  endfunction

  assign sum   = add_mul(acc_q, ratio.mul);
  assign reach = sum >= ACC_W'(ratio.div);
  assign step  = !restart && !hold && reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (restart) acc_q <= '0;
    else if (!hold)   acc_q <= fold(sum, ratio.div, reach);
  end

  // R3
  acc_below_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < ACC_W'(ratio.div));
  // R8
  hold_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !restart) |=> $stable(acc_q));
  // R7
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> acc_q == '0);
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic             tick,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick  <= 1'b0;
      count <= '0;
    end else begin
      tick <= step;
      if (step) count <= bump(count);
    end
  end

  // R5
  tick_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> count == CNT_W'($past(count) + CNT_W'(1)));
  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> count == $past(count));
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import usec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [FIELD_W-1:0] cfg_wdata,
  output logic [FIELD_W-1:0] cfg_rdata,
  input  logic               freeze,
  output logic               tick,
  output logic [CNT_W-1:0]   us_count
);
  ratio_t ratio;
  logic   step;

  usec_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_data (cfg_wdata),
    .rd_data (cfg_rdata),
    .ratio   (ratio)
  );

  usec_rate_gen u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_wr),
    .hold    (freeze),
    .ratio   (ratio),
    .step    (step)
  );

  usec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .tick  (tick),
    .count (us_count)
  );

  // R8
  freeze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !tick);
  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!tick && us_count == $past(us_count)));
endmodule

// File: tb/usec_timebase_test.sv
module usec_timebase_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        freeze = 1'b0;
  logic        tick;
  logic [31:0] us_count;

  logic [15:0] w_rdata;
  logic        w_tick;
  logic [7:0]  w_count;

  int tests = 0;
  int fails = 0;
  int gk = 0;
  bit done = 0;

  int mul_tab[7] = '{1, 1, 5, 5, 1, 5, 1};
  int div_tab[7] = '{12, 13, 84, 96, 26, 192, 48};

  always #10 clk = ~clk;  // 50 MHz

  usec_timebase uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .freeze(freeze), .tick(tick), .us_count(us_count)
  );

  usec_timebase #(.CNT_W(8)) uut_w (
    .clk(clk), .rst_n(rst_n), .cfg_wr(1'b0), .cfg_wdata(16'h0000),
    .cfg_rdata(w_rdata), .freeze(1'b0), .tick(w_tick), .us_count(w_count)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step_cyc();
    @(negedge clk);
    gk++;
  endtask

  task automatic set_raw(logic [15:0] w);
    cfg_wr = 1'b1;
    cfg_wdata = w;
    step_cyc();
    cfg_wr = 1'b0;
    chk("R2 readback", {16'h0, cfg_rdata}, {16'h0, w});
    chk("R7 no tick after write", {31'h0, tick}, 32'h0);
  endtask

  // expected advance = floor(k*mul/div) with k counting unfrozen cycles
  function automatic longint expect_adv(longint k, int mul, int dv);
    return (k * mul) / dv;
  endfunction

  task automatic run_window(int mul, int dv, int cycles, bit rnd_frz, string req);
    logic [31:0] base;
    longint k;
    longint prev;
    longint now;
    base = us_count;
    k = 0;
    prev = 0;
    for (int i = 0; i < cycles; i++) begin
      bit f;
      f = rnd_frz ? (($urandom % 4) == 0) : 1'b0;
      freeze = f;
      step_cyc();
      if (!f) k++;
      now = expect_adv(k, mul, dv);
      chk("R3 count", us_count, base + 32'(now));
      chk(f ? "R8 tick held" : "R5 tick", {31'h0, tick}, {31'h0, (now != prev)});
      prev = now;
    end
    freeze = 1'b0;
    chk(req, us_count - base, 32'(expect_adv(k, mul, dv)));
  endtask

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    gk = 0;
    // R1 reset state
    chk("R1 cfg", {16'h0, cfg_rdata}, 32'h000B);
    chk("R1 count", us_count, 32'h0);
    chk("R1 tick", {31'h0, tick}, 32'h0);
    run_window(1, 12, 60, 1'b0, "R1 default ratio");

    // R4 every listed ratio, three full windows each
    for (int s = 0; s < 7; s++) begin
      set_raw({8'(mul_tab[s] - 1), 8'(div_tab[s] - 1)});
      run_window(mul_tab[s], div_tab[s], 3 * div_tab[s], 1'b0, "R4 ratio window");
    end

    // R7 rewrite mid-window clears accumulator, keeps counter
    set_raw({8'd4, 8'd95});
    run_window(5, 96, 50, 1'b0, "R3 partial");
    held = us_count;
    set_raw({8'd4, 8'd95});
    chk("R7 count kept", us_count, held);
    run_window(5, 96, 96, 1'b0, "R7 fresh window");

    // R8 freeze with a write during freeze
    freeze = 1'b1;
    held = us_count;
    cfg_wr = 1'b1;
    cfg_wdata = {8'd0, 8'd12};
    step_cyc();
    cfg_wr = 1'b0;
    chk("R2 write under freeze", {16'h0, cfg_rdata}, 32'h000C);
    for (int i = 0; i < 30; i++) step_cyc();
    chk("R8 count frozen", us_count, held);
    chk("R8 tick frozen", {31'h0, tick}, 32'h0);
    run_window(1, 13, 39, 1'b0, "R8 resume");

    // R9 clamp of oversized mul
    set_raw({8'd9, 8'd3});
    run_window(4, 4, 20, 1'b0, "R9 clamp");

    // random configuration words with random freeze
    for (int r = 0; r < 4; r++) begin
      logic [15:0] w;
      int m;
      int d;
      w = 16'($urandom);
      m = int'(w[15:8]) + 1;
      d = int'(w[7:0]) + 1;
      if (m > d) m = d;
      set_raw(w);
      run_window(m, d, 2 * d, 1'b1, "R3 random word");
    end

    // long random-freeze run at 19.2 MHz ratio
    set_raw({8'd4, 8'd95});
    run_window(5, 96, 2000, 1'b1, "R8 random freeze");

    // R6 narrow instance wraps
    chk("R6 wrapped", {31'h0, (gk / 12) >= 256}, 32'h1);
    chk("R6 wrap value", {24'h0, w_count}, 32'((gk / 12) % 256));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule